// File: doc/BRIEF.md
# Debounced Latched Interrupt Controller

The block takes a group of external event lines and runs each one through a two-flop synchronizer and then a debounce filter. A line counts as having changed only when its new level has held for that line's own number of clock cycles. When a line's filtered level goes from low to high, a pending bit for that line is set and stays set until software removes it by writing a 1 to it. A mask bit for each line decides whether its pending bit may drive the single active-high interrupt output. At reset every line is masked, so the host starts out by polling.

A small synchronous register port gives access. Offset 0 holds the pending bits. Reads return them, and a write of 1 to a bit clears it. Offset 1 holds the mask, which can be read and written. Offset 2 is a read-only view of the present filtered level of each line. That view is not latched and nothing can clear it. Read data is combinational from the address.

Top module: `irq_latch_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when some pending bit is 1 and its mask bit is 0. It follows register changes in the cycle after the write edge, with no further delay.
- R2: A low-to-high change of a line's filtered level sets that line's pending bit. The bit stays 1 after the line returns low.
- R3: A write to offset 0 clears each pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged.
- R4: If a filtered rising edge and a clearing write hit the same pending bit in the same cycle, the bit stays 1.
- R5: After reset all pending bits read 0, the mask at offset 1 reads all ones, and `irq_o` is 0.
- R6: A masked line still sets its pending bit, and the bit can be read at offset 0.
- R7: Writing 0 to the mask bit of a line whose pending bit is already 1 raises `irq_o` right after that write.
- R8: Offset 2 returns the filtered level of each line in bit order. Writes to offset 2 have no effect on any register or on `irq_o`.
- R9: A raw level change shows up in the filtered level, and in any pending bit, on the clock edge DB+2 after the first edge that samples it. DB is the line's debounce length: 4, 6, 8 and 12 cycles for lines 0 to 3 by default. A pulse shorter than DB cycles changes neither the pending bits nor offset 2.
- R10: Offset 1 reads back the last value written to it, and offset 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Raw event lines, asynchronous |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register offset |
| wdata_i | input | NUM_SRC | Register write data |
| rdata_o | output | NUM_SRC | Register read data, combinational |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The case that is hardest to reach from the ports is a clearing write that lands on exactly the edge where a new filtered rise sets the same pending bit. To reach it, the bench first sets line 0's pending bit and lets the line settle low again. It then raises the line on a falling clock edge and counts DB+1 rising edges. At that point it checks that offset 2 still reads low, so the timing is confirmed. It then places the clearing write on the next edge. Reading offset 2 high right after that write proves the two events coincided, and the pending bit must still read 1.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic [1:0] {
    REG_PEND  = 2'd0,
    REG_MASK  = 2'd1,
    REG_LEVEL = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_debounce.sv
module irq_debounce #(
  parameter int unsigned PERIOD = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             differ;
  logic             done;

  assign differ = in_i ^ lvl_q;
  assign done   = differ && (cnt_q == LAST);

  // counter restarts whenever the input matches the held level again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (done) begin
      cnt_q <= '0;
      lvl_q <= in_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = done && in_i;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  reg_sel_e         sel;
  logic [NUM_SRC-1:0] pend_q, mask_q, clr;

  assign sel = reg_sel_e'(addr_i);
  assign clr = (we_i && sel == REG_PEND) ? wdata_i : '0;

  // a new rise beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mask_q <= '1;
    else if (we_i && sel == REG_MASK) mask_q <= wdata_i;
  end

  always_comb begin
    unique case (sel)
      REG_PEND:  rdata_o = pend_q;
      REG_MASK:  rdata_o = mask_q;
      REG_LEVEL: rdata_o = lvl_i;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o  = |(pend_q & ~mask_q);
  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int unsigned           NUM_SRC = 4,
  parameter int unsigned           CNT_W   = 8,
  parameter logic [NUM_SRC*8-1:0] DB_CYC  = {8'd12, 8'd8, 8'd6, 8'd4}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] evt_sync, db_lvl, db_rise, pend_q, mask_q;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (evt_i),
    .q_o   (evt_sync)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_db
    irq_debounce #(
      .PERIOD(int'(DB_CYC[i*8 +: 8])),
      .CNT_W (CNT_W)
    ) u_db (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (evt_sync[i]),
      .lvl_o (db_lvl[i]),
      .rise_o(db_rise[i])
    );
  end

  irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rise_i (db_rise),
    .lvl_i  (db_lvl),
    .rdata_o(rdata_o),
    .pend_o (pend_q),
    .mask_o (mask_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [1:0]         addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] rise_i,
  input logic [NUM_SRC-1:0] lvl_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic               irq_i
);
  assert_masked_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_i);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr;
    assign clr = we_i && (addr_i == 2'd0) && wdata_i[i];

    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[i] && !clr) |=> pend_i[i]);

    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !rise_i[i]) |=> !pend_i[i]);

    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[i] |=> pend_i[i]);

    assert_rise_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[i] |-> (!lvl_i[i] ##1 lvl_i[i]));
  end
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rise_i (db_rise),
  .lvl_i  (db_lvl),
  .pend_i (pend_q),
  .mask_i (mask_q),
  .irq_i  (irq_o)
);

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         we_i = 1'b0;
  logic [1:0]   addr_i = '0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk_i = ~clk_i;

  irq_latch_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {raw[4], hold[8], we, addr[2], wdata[4], exp_rd[4], exp_irq}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'b0001, 8'd20, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b0},  // R6 masked latch
    {4'b0001, 8'd2,  1'b0, 2'd2, 4'b0000, 4'b0001, 1'b0},  // R8 level
    {4'b0000, 8'd20, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b0},  // R2 sticky
    {4'b0000, 8'd1,  1'b1, 2'd1, 4'b1110, 4'b1110, 1'b1},  // R7 unmask pending
    {4'b0000, 8'd1,  1'b1, 2'd0, 4'b0000, 4'b0001, 1'b1},  // R3 zero no effect
    {4'b0000, 8'd1,  1'b1, 2'd0, 4'b0001, 4'b0000, 1'b0},  // R3 clear
    {4'b0110, 8'd20, 1'b0, 2'd0, 4'b0000, 4'b0110, 1'b0},  // R2 two lines
    {4'b0110, 8'd1,  1'b1, 2'd1, 4'b0000, 4'b0000, 1'b1},  // R1 R10
    {4'b0110, 8'd1,  1'b1, 2'd2, 4'b1111, 4'b0110, 1'b1},  // R8 write ignored
    {4'b0110, 8'd1,  1'b1, 2'd0, 4'b0010, 4'b0100, 1'b1},  // R3 partial
    {4'b0110, 8'd1,  1'b1, 2'd0, 4'b0100, 4'b0000, 1'b0},  // R1 none left
    {4'b1000, 8'd20, 1'b0, 2'd0, 4'b0000, 4'b1000, 1'b1},  // R2 line 3
    {4'b1000, 8'd1,  1'b1, 2'd1, 4'b1000, 4'b1000, 1'b0},  // R1 masked
    {4'b1000, 8'd1,  1'b0, 2'd3, 4'b0000, 4'b0000, 1'b0},  // R10 hole
    {4'b0000, 8'd20, 1'b1, 2'd0, 4'b1000, 4'b0000, 1'b0}   // R3
  };

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic read(input logic [1:0] a, output logic [N-1:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic write(input logic [1:0] a, input logic [N-1:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  initial begin
    logic [N-1:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 reset state
    read(2'd0, rd); check("R5 pending", rd, '0);
    read(2'd1, rd); check("R5 mask", rd, '1);
    check("R5 irq", N'(irq_o), '0);

    for (int v = 0; v < NV; v++) begin
      evt_i = VEC[v][23:20];
      repeat (int'(VEC[v][19:12])) @(negedge clk_i);
      if (VEC[v][11]) write(VEC[v][10:9], VEC[v][8:5]);
      read(VEC[v][10:9], rd);
      check($sformatf("R1-table step %0d rdata", v), rd, VEC[v][4:1]);
      check($sformatf("R1 step %0d irq", v), N'(irq_o), N'(VEC[v][0]));
    end

    // R9 short pulse on line 0 (DB=4) is filtered
    evt_i = 4'b0001;
    repeat (2) @(negedge clk_i);
    evt_i = '0;
    repeat (20) @(negedge clk_i);
    read(2'd0, rd); check("R9 pulse pending", rd, '0);
    read(2'd2, rd); check("R9 pulse level", rd, '0);

    // set line 0 pending, then let it settle low
    evt_i = 4'b0001;
    repeat (20) @(negedge clk_i);
    evt_i = '0;
    repeat (20) @(negedge clk_i);
    read(2'd0, rd); check("R2 prep", rd, 4'b0001);

    // R4 clear lands on the rise edge (edge DB+2 = 6)
    evt_i = 4'b0001;
    repeat (5) @(negedge clk_i);
    read(2'd2, rd); check("R9 level before DB+2", rd, '0);
    write(2'd0, 4'b0001);
    read(2'd2, rd); check("R9 level at DB+2", rd, 4'b0001);
    read(2'd0, rd); check("R4 set wins over clear", rd, 4'b0001);
    write(2'd1, 4'b1110);
    check("R7 irq after unmask", N'(irq_o), N'(1));
    write(2'd0, 4'b0001);
    read(2'd0, rd); check("R3 clear after", rd, '0);
    check("R1 irq low", N'(irq_o), '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule